// File: doc/BRIEF.md
# Self-Correcting Ring / Twisted-Ring Counter

This block is a 4-bit shift-register counter with two sequences. A static mode input selects between them. In ring mode a single set bit rotates through the register, so there are four states. In twisted-ring mode the complement of the top bit is fed back into the bottom bit, so there are eight states. The counter moves one step on each clock edge while enable is high.

Alongside the raw register value, the block produces an 8-bit one-hot vector that names the current state of the active sequence. In ring mode each state is decoded from one bit. In twisted-ring mode each state is decoded from one pair of neighbouring bits.

A register code that does not belong to the active sequence can appear after power-up, after a glitch, or after the mode input is changed. Such a code is flagged at once and replaced on the next clock edge with the mode's start code. The counter therefore cannot stay stuck in one of the unused-state loops.

Top module: `twist_ring_counter`

## Requirements
- R1: A synchronous reset loads `count` with 4'b0001 when `mode` is 0 (ring) and with 4'b0000 when `mode` is 1 (twisted ring).
- R2: In ring mode, with `en` high and a legal code, the next code is `{count[2:0], count[3]}`. The sequence is 0001, 0010, 0100, 1000, then 0001 again.
- R3: In twisted-ring mode, with `en` high and a legal code, the next code is `{count[2:0], ~count[3]}`. The sequence is 0000, 0001, 0011, 0111, 1111, 1110, 1100, 1000, then 0000 again.
- R4: With `en` low and a legal code, `count` and `state_vec` keep their values across clock edges.
- R5: In ring mode with a legal code, `state_vec[i]` is 1 exactly when `count` has only bit i set, and `state_vec[7:4]` is 0.
- R6: In twisted-ring mode with a legal code, `state_vec[k]` is 1, where k is the position of `count` in the R3 sequence (0000 gives bit 0, and so on up to 1000, which gives bit 7). All other bits are 0.
- R7: `illegal` is high, in the same cycle and without waiting for a clock edge, in two cases. In ring mode it is high when `count` does not have exactly one bit set. In twisted-ring mode it is high when more than one of the three neighbouring bit pairs differ. While `illegal` is high, `state_vec` is all zero.
- R8: A code flagged by `illegal` is replaced on the next clock edge with the active mode's reset code from R1. This happens whether `en` is high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable |
| mode | input | 1 | 0 = ring, 1 = twisted ring; held static in normal use |
| count | output | 4 | Raw counter register |
| state_vec | output | 8 | One-hot decoded state, all zero when the code is illegal |
| illegal | output | 1 | Current code lies outside the active mode's cycle |

## Verification
The assertions are checked on every cycle. They check:
- the reset code for each mode;
- the rotate and twisted-shift step;
- holding while `en` is low;
- recovery on the edge that follows a flagged code;
- that `state_vec` is one-hot for legal codes and all zero for illegal codes;
- that the upper half of `state_vec` is unused in ring mode.

Some behaviour is shown only by the bench scenarios. This covers the full order of both cycles, the exact bit that each state decodes to, and whether a given pattern is legal. Illegal codes are reached only through the ports: the mode is switched while the counter holds a code that is legal in the other sequence, which shows that the flag reacts in the same cycle and that recovery ignores `en`.

// File: rtl/rjc_pkg.sv
package rjc_pkg;
   typedef enum logic {
      RJC_RING  = 1'b0,
      RJC_TWIST = 1'b1
   } rjc_mode_e;

   localparam int RJC_MIN_WIDTH = 2;
endpackage

// File: rtl/rjc_legal.sv
module rjc_legal #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic         mode,
   output logic         legal
);
   import rjc_pkg::*;

   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] ones;
   logic [CW-1:0] edges;
   logic [W-2:0]  diff;

   // Neighbouring-bit differences: a twisted-ring code has at most one boundary
   for (genvar i = 0; i < W - 1; i++) begin : g_diff
      assign diff[i] = q[i] ^ q[i+1];
   end

   always_comb begin
      ones  = '0;
      edges = '0;
      for (int i = 0; i < W; i++)
         ones = ones + CW'(q[i]);
      for (int i = 0; i < W - 1; i++)
         edges = edges + CW'(diff[i]);
   end

   always_comb begin
      if (rjc_mode_e'(mode) == RJC_RING)
         legal = (ones == CW'(1));
      else
         legal = (edges <= CW'(1));
   end
endmodule

// File: rtl/rjc_decode.sv
module rjc_decode #(
   parameter int W = 4
) (
   input  logic [W-1:0]   q,
   input  logic           mode,
   input  logic           legal,
   output logic [2*W-1:0] vec
);
   import rjc_pkg::*;

   localparam int DW = 2 * W;

   logic [DW-1:0] tw_vec;
   logic [DW-1:0] rg_vec;

   // Twisted-ring decode: every state is one two-input gate on a bit pair
   for (genvar k = 0; k < W; k++) begin : g_tw
      if (k == 0) begin : g_first
         assign tw_vec[0] = ~q[W-1] & ~q[0];
         assign tw_vec[W] =  q[W-1] &  q[0];
      end else begin : g_mid
         assign tw_vec[k]     =  q[k-1] & ~q[k];
         assign tw_vec[W + k] = ~q[k-1] &  q[k];
      end
   end

   // Ring decode: every state is a single bit
   assign rg_vec = {{W{1'b0}}, q};

   always_comb begin
      if (!legal)
         vec = '0;
      else if (rjc_mode_e'(mode) == RJC_RING)
         vec = rg_vec;
      else
         vec = tw_vec;
   end
endmodule

// File: rtl/rjc_next.sv
module rjc_next #(
   parameter int W = 4
) (
   input  logic [W-1:0] q,
   input  logic         mode,
   input  logic         en,
   input  logic         legal,
   output logic [W-1:0] d
);
   import rjc_pkg::*;

   logic [W-1:0] shifted;
   logic [W-1:0] restart;
   logic         feed;

   assign feed = (rjc_mode_e'(mode) == RJC_TWIST) ? ~q[W-1] : q[W-1];

   for (genvar i = 0; i < W; i++) begin : g_shift
      if (i == 0) begin : g_in
         assign shifted[i] = feed;
      end else begin : g_pass
         assign shifted[i] = q[i-1];
      end
   end

   assign restart = (rjc_mode_e'(mode) == RJC_TWIST) ? '0 : W'(1);

   always_comb begin
      if (!legal)
         d = restart;
      else if (en)
         d = shifted;
      else
         d = q;
   end
endmodule

// File: rtl/twist_ring_counter.sv
module twist_ring_counter #(
   parameter int WIDTH = 4
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               mode,
   output logic [WIDTH-1:0]   count,
   output logic [2*WIDTH-1:0] state_vec,
   output logic               illegal
);
   import rjc_pkg::*;

   localparam int DW = 2 * WIDTH;

   if (WIDTH < RJC_MIN_WIDTH) begin : g_bad_width
      $error("twist_ring_counter: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] d;
   logic             legal;
   logic [DW-1:0]    vec;

   rjc_legal #(.W(WIDTH)) u_legal (
      .q     (count),
      .mode  (mode),
      .legal (legal)
   );

   rjc_next #(.W(WIDTH)) u_next (
      .q     (count),
      .mode  (mode),
      .en    (en),
      .legal (legal),
      .d     (d)
   );

   rjc_decode #(.W(WIDTH)) u_dec (
      .q     (count),
      .mode  (mode),
      .legal (legal),
      .vec   (vec)
   );

   always_ff @(posedge clk) begin
      if (rst)
         count <= (rjc_mode_e'(mode) == RJC_TWIST) ? '0 : WIDTH'(1);
      else
         count <= d;
   end

   assign state_vec = vec;
   assign illegal   = ~legal;
endmodule

// File: rtl/twist_ring_counter_chk.sv
module twist_ring_counter_chk #(
   parameter int W = 4
) (
   input logic           clk,
   input logic           rst,
   input logic           en,
   input logic           mode,
   input logic [W-1:0]   count,
   input logic [2*W-1:0] state_vec,
   input logic           illegal
);
   assert_reset_code_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> count == ($past(mode) ? W'(0) : W'(1)));

   assert_ring_step_R2: assert property (@(posedge clk) disable iff (rst)
      (!mode && en && !illegal) |=> count == {$past(count[W-2:0]), $past(count[W-1])});

   assert_twist_step_R3: assert property (@(posedge clk) disable iff (rst)
      (mode && en && !illegal) |=> count == {$past(count[W-2:0]), ~$past(count[W-1])});

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!en && !illegal) |=> $stable(count));

   assert_ring_upper_zero_R5: assert property (@(posedge clk) disable iff (rst)
      !mode |-> state_vec[2*W-1:W] == '0);

   assert_onehot_legal_R6: assert property (@(posedge clk) disable iff (rst)
      !illegal |-> $countones(state_vec) == 1);

   assert_zero_vec_R7: assert property (@(posedge clk) disable iff (rst)
      illegal |-> state_vec == '0);

   assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
      illegal |=> count == ($past(mode) ? W'(0) : W'(1)));
endmodule

bind twist_ring_counter twist_ring_counter_chk #(.W(WIDTH)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .mode      (mode),
   .count     (count),
   .state_vec (state_vec),
   .illegal   (illegal)
);

// File: tb/twist_ring_counter_test.sv
module twist_ring_counter_test;
   localparam int CLK_PERIOD = 10;
   localparam int W  = 4;
   localparam int DW = 2 * W;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          en  = 1'b0;
   logic          mode = 1'b0;
   logic [W-1:0]  count;
   logic [DW-1:0] state_vec;
   logic          illegal;

   int n_chk  = 0;
   int n_fail = 0;
   logic [W-1:0] mq = '0;

   twist_ring_counter #(.WIDTH(W)) uut (
      .clk(clk), .rst(rst), .en(en), .mode(mode),
      .count(count), .state_vec(state_vec), .illegal(illegal)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- independent reference model ----------------
   function automatic logic [W-1:0] m_step(logic [W-1:0] v, logic md);
      logic [W-1:0] r;
      for (int i = W - 1; i > 0; i--) r[i] = v[i-1];
      r[0] = md ? ~v[W-1] : v[W-1];
      return r;
   endfunction

   function automatic int m_index(logic [W-1:0] v, logic md);
      logic [W-1:0] s;
      s = md ? '0 : W'(1);
      for (int k = 0; k < (md ? DW : W); k++) begin
         if (s == v) return k;
         s = m_step(s, md);
      end
      return -1;
   endfunction

   function automatic logic [DW-1:0] m_vec(logic [W-1:0] v, logic md);
      int k;
      k = m_index(v, md);
      if (k < 0) return '0;
      return DW'(1) << k;
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check({tag, " count"}, 32'(count), 32'(mq));
      check({tag, " state_vec"}, 32'(state_vec), 32'(m_vec(mq, mode)));
      check({tag, " illegal"}, 32'(illegal), 32'(m_index(mq, mode) < 0));
   endtask

   // One clock: inputs already driven at the negedge; update model, sample at next negedge
   task automatic step();
      if (rst) mq = mode ? '0 : W'(1);
      else if (m_index(mq, mode) < 0) mq = mode ? '0 : W'(1);
      else if (en) mq = m_step(mq, mode);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset(logic md);
      mode = md; rst = 1'b1; en = 1'b0;
      step();
      rst = 1'b0;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      do_reset(1'b0);
      check("R1 ring reset", 32'(count), 32'h1);
      check_all("R1/R5 ring reset");
      do_reset(1'b1);
      check("R1 twist reset", 32'(count), 32'h0);
      check_all("R1/R6 twist reset");
   endtask

   task automatic t_ring_cycle();
      do_reset(1'b0);
      en = 1'b1;
      for (int i = 0; i < 5; i++) begin
         step();
         check_all("R2/R5 ring cycle");
      end
      check("R2 ring wrap", 32'(count), 32'h2);
      check("R5 ring vec bit1", 32'(state_vec), 32'h02);
   endtask

   task automatic t_twist_cycle();
      do_reset(1'b1);
      en = 1'b1;
      for (int i = 0; i < 9; i++) begin
         step();
         check_all("R3/R6 twist cycle");
         if (i == 4) begin
            check("R3 twist 1110", 32'(count), 32'hE);
            check("R6 twist 1110 -> bit5", 32'(state_vec), 32'h20);
         end
      end
      check("R3 twist wrap 0001", 32'(count), 32'h1);
   endtask

   task automatic t_hold();
      do_reset(1'b1);
      en = 1'b1;
      step(); step(); step();
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         check("R4 twist hold count", 32'(count), 32'h7);
         check_all("R4 twist hold");
      end
      do_reset(1'b0);
      en = 1'b1;
      step(); step();
      en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         step();
         check("R4 ring hold count", 32'(count), 32'h4);
         check_all("R4 ring hold");
      end
   endtask

   task automatic t_recover_ring();
      do_reset(1'b1);
      en = 1'b1;
      step(); step();            // 0011
      en = 1'b0;
      mode = 1'b0;               // 0011 is not a ring code
      #1;
      check("R7 ring illegal flag", 32'(illegal), 32'h1);
      check("R7 ring vec zero", 32'(state_vec), 32'h0);
      step();
      check("R8 ring recover with en low", 32'(count), 32'h1);
      check_all("R8 ring recovered");
   endtask

   task automatic t_recover_twist();
      do_reset(1'b0);
      en = 1'b1;
      step();                    // 0010
      mode = 1'b1;               // 0010 is not a twisted-ring code
      #1;
      check("R7 twist illegal flag", 32'(illegal), 32'h1);
      check("R7 twist vec zero", 32'(state_vec), 32'h0);
      step();
      check("R8 twist recover", 32'(count), 32'h0);
      check_all("R8 twist recovered");
      step();
      check("R3 twist resumes", 32'(count), 32'h1);
   endtask

   task automatic t_legal_other_mode();
      // 1000 is legal in both sequences: switching mode keeps it
      do_reset(1'b0);
      en = 1'b1;
      step(); step(); step();    // 1000
      en = 1'b0;
      mode = 1'b1;
      #1;
      check("R7 1000 legal in twist", 32'(illegal), 32'h0);
      check("R6 1000 -> bit7", 32'(state_vec), 32'h80);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_ring_cycle();
      t_twist_cycle();
      t_hold();
      t_recover_ring();
      t_recover_twist();
      t_legal_other_mode();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule